// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line Error Flags

This block turns one asynchronous serial input into characters. A free-running oversampling enable, sixteen pulses per bit time, paces it. It finds the falling edge of a start bit and confirms that bit at its midpoint. It then samples each data bit, the optional parity bit and the stop bit at the middle of its bit period. Each completed character is handed out on a one-clock valid strobe, together with three per-character flags: parity mismatch, bad stop bit and break.

Two line conditions get special handling. If the stop bit is sampled low, the receiver takes that low level as the start bit of the next character and keeps receiving with no idle gap. If every sample of a whole character is low, the receiver reports a break as one zero character. It then ignores the line until it has seen the line return to logic 1. Word length and parity are set by static configuration inputs. Baud generation, buffering and any software access are left to the surrounding logic.

Top module: `uart_rx_errchk`

## Requirements
- R1: A frame made of a low start bit, data bits sent least significant bit first, and a high stop bit is delivered on `rx_data` with `rx_perr`, `rx_ferr` and `rx_brk` all low.
- R2: The word length is 5 plus the value of `cfg_wlen` (0 to 3). Bits of `rx_data` above the word length read as 0.
- R3: When `cfg_par_en` is 1, one parity bit follows the data bits. `cfg_par_mode` selects its expected value: 0 odd, 1 even, 2 always 1, 3 always 0. A received parity bit that differs from this value sets `rx_perr`, and the data is still delivered.
- R4: A stop bit sampled at 0 sets `rx_ferr` for that character, unless the character is a break (R6).
- R5: After a bad stop bit, that low stop bit counts as the start bit of the next character. The next character's data bits are sampled straight after it, with no idle time, and that character is recovered correctly.
- R6: When the start, data, parity (if enabled) and stop samples of one character are all 0, a single character of value 0x00 is delivered with `rx_brk` = 1, `rx_ferr` = 0 and `rx_perr` = 0.
- R7: After a break, no further character is delivered while the line stays low. Reception resumes only after the line has been seen at 1.
- R8: Every bit is sampled on the 8th of its 16 oversampling pulses. A start bit that is no longer low at its midpoint is discarded and produces no character.
- R9: `rx_valid` is high for exactly one clock per character, in the cycle after the oversampling pulse on which the stop bit is sampled.
- R10: Under synchronous reset, `rx_valid`, `rx_data` and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling enable, OSR pulses per bit time |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_wlen | input | 2 | Word length minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_mode | input | 2 | 0 odd, 1 even, 2 always 1, 3 always 0 |
| rx_valid | output | 1 | One-clock strobe per character |
| rx_data | output | 8 | Received character, zero-extended |
| rx_perr | output | 1 | Parity mismatch for this character |
| rx_ferr | output | 1 | Stop bit sampled low |
| rx_brk | output | 1 | Break detected |

## Verification
The bench builds the block with its defaults: OSR = 16 and a two-stage input synchronizer. The oversampling pulse comes every fourth clock, so one bit lasts 64 clocks. This spacing gives enough slack around the midpoint that synchronizer delay and pulse phase cannot move a sample into a neighbouring bit. It also makes a glitch of three pulses short enough to check start-bit rejection. The same setup is long enough to drive a framing error followed directly by a resynchronised character, and a break held well past one character time so the lockout can be seen.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    PAR_ODD  = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ONE  = 2'd2,
    PAR_ZERO = 2'd3
  } par_mode_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_DATA  = 3'd2,
    S_PAR   = 3'd3,
    S_STOP  = 3'd4,
    S_MARK  = 3'd5
  } rx_state_e;

  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rx_flags_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  // Reset to the marking level so that reset never looks like a start bit.
  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/rx_parity_gen.sv
module rx_parity_gen
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  par_mode_e         mode,
  output logic              exp_bit
);
  logic ones_odd;

  // Bits above the word length are held at zero, so a full-width XOR is exact.
  assign ones_odd = ^data;

  always_comb begin
    unique case (mode)
      PAR_ODD:  exp_bit = ~ones_odd;
      PAR_EVEN: exp_bit = ones_odd;
      PAR_ONE:  exp_bit = 1'b1;
      default:  exp_bit = 1'b0;
    endcase
  end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8,
  parameter int WL_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              rxs,
  input  logic [WL_W-1:0]   cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              exp_par,
  output logic [DATA_W-1:0] shreg,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output rx_flags_t         out_flags
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int MIN_W = DATA_W - (1 << WL_W) + 1;
  localparam logic [CNT_W-1:0] MID_M1  = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] LAST_OS = CNT_W'(OSR - 1);

  rx_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] bit_idx;
  logic             all_low;
  logic             par_bit;
  logic [IDX_W-1:0] last_idx;
  logic             bit_end;
  logic             is_brk;

  assign last_idx = IDX_W'(MIN_W - 1) + IDX_W'(cfg_wlen);
  assign bit_end  = (cnt == LAST_OS);
  assign is_brk   = all_low & ~rxs;

  always_ff @(posedge clk) begin
    out_valid <= 1'b0;
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      all_low   <= 1'b0;
      par_bit   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_flags <= '0;
    end else if (os_tick) begin
      unique case (state)
        S_IDLE: begin
          if (!rxs) begin
            state <= S_START;
            cnt   <= CNT_W'(1);
          end
        end
        S_START: begin
          if (cnt == MID_M1) begin
            if (rxs) begin
              state <= S_IDLE;
            end else begin
              state   <= S_DATA;
              cnt     <= '0;
              bit_idx <= '0;
              shreg   <= '0;
              all_low <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: begin
          if (bit_end) begin
            cnt            <= '0;
            shreg[bit_idx] <= rxs;
            all_low        <= all_low & ~rxs;
            if (bit_idx == last_idx) state <= cfg_par_en ? S_PAR : S_STOP;
            else                     bit_idx <= bit_idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PAR: begin
          if (bit_end) begin
            cnt     <= '0;
            par_bit <= rxs;
            all_low <= all_low & ~rxs;
            state   <= S_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STOP: begin
          if (bit_end) begin
            cnt            <= '0;
            out_valid      <= 1'b1;
            out_data       <= is_brk ? '0 : shreg;
            out_flags.brk  <= is_brk;
            out_flags.ferr <= ~rxs & ~all_low;
            out_flags.perr <= cfg_par_en & (par_bit ^ exp_par) & ~is_brk;
            if (is_brk) begin
              state <= S_MARK;
            end else if (!rxs) begin
              // Low stop bit is taken as the next start bit, already confirmed at mid.
              state   <= S_DATA;
              bit_idx <= '0;
              shreg   <= '0;
              all_low <= 1'b1;
            end else begin
              state <= S_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_MARK: begin
          if (rxs) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_errchk.sv
module uart_rx_errchk
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int WL_W        = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              rx_line,
  input  logic [WL_W-1:0]   cfg_wlen,
  input  logic              cfg_par_en,
  input  logic [1:0]        cfg_par_mode,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_perr,
  output logic              rx_ferr,
  output logic              rx_brk
);
  logic              rxs;
  logic              exp_par;
  logic [DATA_W-1:0] shreg;
  rx_flags_t         flags;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (rx_line),
    .q_sync  (rxs)
  );

  rx_parity_gen #(.DATA_W(DATA_W)) u_par (
    .data    (shreg),
    .mode    (par_mode_e'(cfg_par_mode)),
    .exp_bit (exp_par)
  );

  rx_frame_fsm #(.OSR(OSR), .DATA_W(DATA_W), .WL_W(WL_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .os_tick    (os_tick),
    .rxs        (rxs),
    .cfg_wlen   (cfg_wlen),
    .cfg_par_en (cfg_par_en),
    .exp_par    (exp_par),
    .shreg      (shreg),
    .out_valid  (rx_valid),
    .out_data   (rx_data),
    .out_flags  (flags)
  );

  assign rx_perr = flags.perr;
  assign rx_ferr = flags.ferr;
  assign rx_brk  = flags.brk;
endmodule

// File: rtl/uart_rx_errchk_chk.sv
module uart_rx_errchk_chk #(
  parameter int DATA_W = 8,
  parameter int WL_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              os_tick,
  input logic              rx_line,
  input logic [WL_W-1:0]   cfg_wlen,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_perr,
  input logic              rx_ferr,
  input logic              rx_brk
);
  logic [DATA_W-1:0] wl_mask;
  logic              locked;

  assign wl_mask = {DATA_W{1'b1}} >> ((1 << WL_W) - 1 - int'(cfg_wlen));

  always_ff @(posedge clk) begin
    if (rst)                     locked <= 1'b0;
    else if (rx_valid && rx_brk) locked <= 1'b1;
    else if (rx_line)            locked <= 1'b0;
  end

  AST_RESET_QUIET:   assert property (@(posedge clk) rst |=> (!rx_valid && !rx_brk && !rx_ferr && !rx_perr)); // R10
  AST_ONE_CLK_VALID: assert property (@(posedge clk) disable iff (rst) rx_valid |=> !rx_valid); // R9
  AST_VALID_ON_TICK: assert property (@(posedge clk) disable iff (rst) $rose(rx_valid) |-> $past(os_tick)); // R9
  AST_BRK_CLEAN:     assert property (@(posedge clk) disable iff (rst) (rx_valid && rx_brk) |-> (!rx_ferr && !rx_perr && rx_data == '0)); // R6
  AST_WORD_WIDTH:    assert property (@(posedge clk) disable iff (rst) rx_valid |-> ((rx_data & ~wl_mask) == '0)); // R2
  AST_BRK_LOCKOUT:   assert property (@(posedge clk) disable iff (rst) locked |-> !rx_valid); // R7
endmodule

bind uart_rx_errchk uart_rx_errchk_chk #(.DATA_W(DATA_W), .WL_W(WL_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .os_tick  (os_tick),
  .rx_line  (rx_line),
  .cfg_wlen (cfg_wlen),
  .rx_valid (rx_valid),
  .rx_data  (rx_data),
  .rx_perr  (rx_perr),
  .rx_ferr  (rx_ferr),
  .rx_brk   (rx_brk)
);

// File: tb/tb_uart_rx_errchk.sv
`timescale 1ns/1ps
module tb_uart_rx_errchk;
  localparam int OSR      = 16;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLK  = OSR * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       os_tick;
  logic       rx_line = 1'b1;
  logic [1:0] cfg_wlen = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic [1:0] cfg_par_mode = 2'd0;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_perr, rx_ferr, rx_brk;

  int nchk = 0;
  int nerr = 0;
  int cap_n = 0;
  int dbl_n = 0;
  bit prev_v = 1'b0;
  bit done = 1'b0;
  int div = 0;
  logic [7:0] cap_d [64];
  logic [2:0] cap_f [64];

  always #2.5 clk = ~clk;

  uart_rx_errchk dut (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rx_line(rx_line),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_mode(cfg_par_mode),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
    .rx_ferr(rx_ferr), .rx_brk(rx_brk)
  );

  always @(posedge clk) begin
    if (rst) begin
      div <= 0;
      os_tick <= 1'b0;
    end else begin
      div <= (div == TICK_DIV - 1) ? 0 : div + 1;
      os_tick <= (div == TICK_DIV - 1);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        cap_d[cap_n % 64] = rx_data;
        cap_f[cap_n % 64] = {rx_brk, rx_ferr, rx_perr};
        cap_n++;
      end
      if (rx_valid && prev_v) dbl_n++;
      prev_v = rx_valid;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rx_line = b;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic idle_bits(input int n);
    rx_line = 1'b1;
    repeat (n * BIT_CLK) @(negedge clk);
  endtask

  task automatic send_body(input logic [7:0] d, input int nb, input bit pen, input bit pbit, input bit stopb);
    for (int i = 0; i < nb; i++) send_bit(d[i]);
    if (pen) send_bit(pbit);
    send_bit(stopb);
  endtask

  function automatic bit par_of(input logic [7:0] d, input int mode);
    bit x = ^d;
    case (mode)
      0: return ~x;
      1: return x;
      2: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check_cap(input int idx, input logic [7:0] d, input logic [2:0] f, input string req);
    chk(cap_d[idx % 64] == d, {req, " data"}, cap_d[idx % 64], d);
    chk(cap_f[idx % 64] == f, {req, " flags brk/ferr/perr"}, cap_f[idx % 64], f);
  endtask

  task automatic set_cfg(input int wl, input bit pen, input int mode);
    cfg_wlen = 2'(wl - 5);
    cfg_par_en = pen;
    cfg_par_mode = 2'(mode);
  endtask

  // R10: outputs quiet during and right after reset
  task automatic t_reset();
    chk({rx_valid, rx_data, rx_perr, rx_ferr, rx_brk} == '0, "R10 reset state",
        {rx_valid, rx_data, rx_perr, rx_ferr, rx_brk}, 0);
  endtask

  // R1: plain 8-bit frames
  task automatic t_basic();
    int n0 = cap_n;
    set_cfg(8, 0, 0);
    send_bit(0); send_body(8'hA5, 8, 0, 0, 1); idle_bits(1);
    send_bit(0); send_body(8'h3E, 8, 0, 0, 1); idle_bits(1);
    chk(cap_n == n0 + 2, "R1 count", cap_n - n0, 2);
    check_cap(n0, 8'hA5, 3'b000, "R1 a5");
    check_cap(n0 + 1, 8'h3E, 3'b000, "R1 3e");
  endtask

  // R2/R3: short words with correct parity of each mode
  task automatic t_wordlen();
    int n0 = cap_n;
    set_cfg(5, 1, 1);
    send_bit(0); send_body(8'h13, 5, 1, par_of(8'h13, 1), 1); idle_bits(1);
    set_cfg(6, 1, 3);
    send_bit(0); send_body(8'h2A, 6, 1, 1'b0, 1); idle_bits(1);
    set_cfg(7, 1, 0);
    send_bit(0); send_body(8'h55, 7, 1, par_of(8'h55, 0), 1); idle_bits(1);
    set_cfg(5, 0, 0);
    send_bit(0); send_body(8'hFF, 5, 0, 0, 1); idle_bits(1);
    chk(cap_n == n0 + 4, "R2 count", cap_n - n0, 4);
    check_cap(n0, 8'h13, 3'b000, "R2 R3 5-bit even");
    check_cap(n0 + 1, 8'h2A, 3'b000, "R2 R3 6-bit zero");
    check_cap(n0 + 2, 8'h55, 3'b000, "R2 R3 7-bit odd");
    check_cap(n0 + 3, 8'h1F, 3'b000, "R2 5-bit upper zero");
  endtask

  // R3: wrong parity bits
  task automatic t_parity_err();
    int n0 = cap_n;
    set_cfg(8, 1, 0);
    send_bit(0); send_body(8'hA5, 8, 1, ~par_of(8'hA5, 0), 1); idle_bits(1);
    set_cfg(7, 1, 2);
    send_bit(0); send_body(8'h41, 7, 1, 1'b0, 1); idle_bits(1);
    set_cfg(6, 1, 3);
    send_bit(0); send_body(8'h21, 6, 1, 1'b1, 1); idle_bits(1);
    set_cfg(8, 1, 1);
    send_bit(0); send_body(8'h01, 8, 1, ~par_of(8'h01, 1), 1); idle_bits(1);
    chk(cap_n == n0 + 4, "R3 count", cap_n - n0, 4);
    check_cap(n0, 8'hA5, 3'b001, "R3 odd wrong");
    check_cap(n0 + 1, 8'h41, 3'b001, "R3 one wrong");
    check_cap(n0 + 2, 8'h21, 3'b001, "R3 zero wrong");
    check_cap(n0 + 3, 8'h01, 3'b001, "R3 even wrong");
  endtask

  // R4/R5: bad stop bit becomes the next start bit
  task automatic t_framing();
    int n0 = cap_n;
    set_cfg(8, 0, 0);
    send_bit(0); send_body(8'h3C, 8, 0, 0, 0);
    send_body(8'h5A, 8, 0, 0, 1); idle_bits(2);
    chk(cap_n == n0 + 2, "R5 count", cap_n - n0, 2);
    check_cap(n0, 8'h3C, 3'b010, "R4 ferr");
    check_cap(n0 + 1, 8'h5A, 3'b000, "R5 resync");
  endtask

  // R6/R7: break, lockout, recovery
  task automatic t_break();
    int n0 = cap_n;
    set_cfg(7, 1, 1);
    rx_line = 1'b0;
    repeat (15 * BIT_CLK) @(negedge clk);
    chk(cap_n == n0 + 1, "R7 single char while low", cap_n - n0, 1);
    check_cap(n0, 8'h00, 3'b100, "R6 break");
    idle_bits(2);
    chk(cap_n == n0 + 1, "R7 no char on release", cap_n - n0, 1);
    set_cfg(8, 0, 0);
    send_bit(0); send_body(8'h81, 8, 0, 0, 1); idle_bits(1);
    chk(cap_n == n0 + 2, "R7 resume count", cap_n - n0, 2);
    check_cap(n0 + 1, 8'h81, 3'b000, "R7 resume");
  endtask

  // R8: short low pulse rejected
  task automatic t_glitch();
    int n0 = cap_n;
    set_cfg(8, 0, 0);
    rx_line = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk);
    idle_bits(3);
    chk(cap_n == n0, "R8 glitch ignored", cap_n - n0, 0);
    send_bit(0); send_body(8'h66, 8, 0, 0, 1); idle_bits(1);
    chk(cap_n == n0 + 1, "R8 after glitch count", cap_n - n0, 1);
    check_cap(n0, 8'h66, 3'b000, "R8 after glitch");
  endtask

  // R9: every strobe lasted one clock
  task automatic t_pulse();
    chk(dbl_n == 0, "R9 single-clock valid", dbl_n, 0);
    chk(rx_valid == 1'b0, "R9 valid idle low", rx_valid, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst = 1'b0;
    idle_bits(2);
    t_basic();
    t_wordlen();
    t_parity_err();
    t_framing();
    t_break();
    t_glitch();
    t_pulse();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule